// File: doc/BRIEF.md
# Dual-Channel Memory Address Mapper

This block sits between an on-chip requester and a memory subsystem with two independent DRAM channels, A and B. Each channel has its own command/address path. The block takes a logical byte address and returns a channel select and a channel-local physical address.

Three run-time maps are available:

- **Separate:** a low range of the address space lives in channel A and the range above it lives in channel B.
- **Striped:** consecutive 32-byte granules alternate between the two channels.
- **Mixed:** addresses below a programmable boundary stay in channel A, which holds the always-on data. Everything at or above the boundary is striped across both channels, to give bandwidth when both are powered.

A status output tells the power logic when no live address can reach channel B. Requests enter through a valid/ready handshake. Results leave through one registered stage with its own valid/ready, giving one result per clock when the consumer is ready. Mode, boundary and enabled capacity are loaded through a one-cycle write strobe. A write is refused while any request is pending.

Top module: `dcam_top`

## Requirements
- R1: Separate mode (mode code 0). An in-range address below the boundary goes to channel A (`out_sel_b`=0) with local address equal to the logical address. An address at or above the boundary goes to channel B with local address equal to the logical address minus the boundary.
- R2: Striped mode (mode code 1). Logical address bit 5 selects the channel (1 = B). The local address is the logical address with bit 5 removed: bits above it shift down by one and bits 4..0 are kept.
- R3: Mixed mode (mode code 2). An in-range address below the effective boundary goes to channel A with local address equal to the logical address.
- R4: Mixed mode, address at or above the effective boundary. Let d = address minus boundary. Bit 5 of d selects the channel, and q = d with bit 5 removed. Channel B receives local address q. Channel A receives the effective boundary plus q.
- R5: In mixed mode, the effective boundary is the written boundary with its low 6 bits cleared.
- R6: An address at or above the enabled capacity gives `out_err`=1 with `out_sel_b`=0 and `out_loc`=0. No channel request is made for it.
- R7: `chb_idle` is 1 in two cases: separate or reserved mode with boundary ≥ capacity, and mixed mode with effective boundary ≥ capacity. It is 0 otherwise, and always 0 in striped mode.
- R8: A configuration write while `req_valid` or `out_valid` is high is discarded. Later requests are mapped with the configuration already in force.
- R9: A request accepted on one clock edge shows its result with `out_valid`=1 after that edge. Back-to-back requests stream at one per clock while `out_ready`=1.
- R10: While `out_valid`=1 and `out_ready`=0, the result holds stable and `req_ready` is 0. No request is lost.
- R11: Mode code 3 behaves exactly like separate mode.
- R12: After reset, `out_valid`=0 and `req_ready`=1. The mode is separate, with boundary and capacity both equal to the full address space, so `chb_idle`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Map code: 0 separate, 1 striped, 2 mixed, 3 as separate |
| cfg_split | input | ADDR_W+1 | Boundary (channel A size in separate mode) |
| cfg_top | input | ADDR_W+1 | Enabled capacity in bytes |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high together with `req_valid` |
| req_addr | input | ADDR_W | Logical byte address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_err | output | 1 | Address beyond enabled capacity |
| out_sel_b | output | 1 | 0 = channel A, 1 = channel B |
| out_loc | output | ADDR_W | Channel-local byte address |
| chb_idle | output | 1 | No live address maps to channel B |

## Verification
Each mapping result is due exactly one clock edge after its request is accepted. The bench drives each request on a falling edge and checks the result of the previous request on the next falling edge, so a sweep compares one address per cycle with the handshake running flat out. `chb_idle` depends only on the configuration in force. It is therefore checked on the falling edge after the write strobe drops, and again after a refused write to show nothing changed. The back-pressure case holds `out_ready` low for several falling edges, checking that the output is stable and `req_ready` is low each time. It then releases the consumer and confirms that the held-off request emerges one edge later.

// File: rtl/dcam_pkg.sv
package dcam_pkg;

    typedef enum logic [1:0] {
        MAP_SPLIT  = 2'd0,
        MAP_STRIPE = 2'd1,
        MAP_MIXED  = 2'd2,
        MAP_RSVD   = 2'd3
    } map_mode_e;

    // Codes 0 and 3 share the range-split map.
    function automatic logic is_split_like(map_mode_e m);
        return (m == MAP_SPLIT) || (m == MAP_RSVD);
    endfunction

endpackage

// File: rtl/dcam_cfg.sv
module dcam_cfg
    import dcam_pkg::*;
#(
    parameter int AW  = 16,
    parameter int GLG = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_mode,
    input  logic [AW:0]   cfg_split,
    input  logic [AW:0]   cfg_top,
    input  logic          busy,
    output map_mode_e     act_mode,
    output logic [AW:0]   act_split,
    output logic [AW:0]   act_top,
    output logic          chb_idle
);
    localparam int          PLG    = GLG + 1;
    localparam logic [AW:0] FULL   = {1'b1, {AW{1'b0}}};
    localparam logic [AW:0] ALMASK = (AW+1)'((1 << PLG) - 1);

    logic [AW:0] split_al;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_mode  <= MAP_SPLIT;
            act_split <= FULL;
            act_top   <= FULL;
        end else if (cfg_wr && !busy) begin
            act_mode  <= map_mode_e'(cfg_mode);
            act_split <= cfg_split;
            act_top   <= cfg_top;
        end
    end

    always_comb begin
        split_al = act_split & ~ALMASK;
        if (is_split_like(act_mode))
            chb_idle = (act_split >= act_top);
        else if (act_mode == MAP_MIXED)
            chb_idle = (split_al >= act_top);
        else
            chb_idle = 1'b0;
    end

endmodule

// File: rtl/dcam_xlate.sv
module dcam_xlate
    import dcam_pkg::*;
#(
    parameter int AW  = 16,
    parameter int GLG = 5
) (
    input  map_mode_e       mode,
    input  logic [AW:0]     split,
    input  logic [AW:0]     top,
    input  logic [AW-1:0]   addr,
    output logic            err,
    output logic            sel_b,
    output logic [AW-1:0]   loc
);
    localparam int          PLG    = GLG + 1;
    localparam logic [AW:0] LOMASK = (AW+1)'((1 << GLG) - 1);
    localparam logic [AW:0] ALMASK = (AW+1)'((1 << PLG) - 1);

    // Drop the channel-select bit and close the gap.
    function automatic logic [AW-1:0] squeeze(input logic [AW:0] v);
        logic [AW:0] hi;
        logic [AW:0] s;
        hi = (v >> PLG) << GLG;
        s  = hi | (v & LOMASK);
        return s[AW-1:0];
    endfunction

    logic [AW:0]   ext;
    logic [AW:0]   split_al;
    logic [AW:0]   diff;
    logic [AW-1:0] sq;

    always_comb begin
        ext      = {1'b0, addr};
        split_al = split & ~ALMASK;
        err      = (ext >= top);
        diff     = '0;
        sq       = '0;
        sel_b    = 1'b0;
        loc      = addr;
        unique case (mode)
            MAP_STRIPE: begin
                sel_b = addr[GLG];
                loc   = squeeze(ext);
            end
            MAP_MIXED: begin
                if (ext >= split_al) begin
                    diff  = ext - split_al;
                    sq    = squeeze(diff);
                    sel_b = diff[GLG];
                    loc   = sel_b ? sq : (split_al[AW-1:0] + sq);
                end
            end
            default: begin
                if (ext >= split) begin
                    diff  = ext - split;
                    sel_b = 1'b1;
                    loc   = diff[AW-1:0];
                end
            end
        endcase
        if (err) begin
            sel_b = 1'b0;
            loc   = '0;
        end
    end

endmodule

// File: rtl/dcam_ostage.sv
module dcam_ostage #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_err,
    input  logic          in_sel_b,
    input  logic [AW-1:0] in_loc,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_err,
    output logic          out_sel_b,
    output logic [AW-1:0] out_loc
);
    typedef struct packed {
        logic          err;
        logic          sel_b;
        logic [AW-1:0] loc;
    } res_t;

    res_t held;

    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            held      <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid)
                held <= '{err: in_err, sel_b: in_sel_b, loc: in_loc};
        end
    end

    assign out_err   = held.err;
    assign out_sel_b = held.sel_b;
    assign out_loc   = held.loc;

endmodule

// File: rtl/dcam_top.sv
module dcam_top
    import dcam_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int GRAN_LG = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_mode,
    input  logic [ADDR_W:0]   cfg_split,
    input  logic [ADDR_W:0]   cfg_top,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_err,
    output logic              out_sel_b,
    output logic [ADDR_W-1:0] out_loc,
    output logic              chb_idle
);
    map_mode_e         act_mode;
    logic [ADDR_W:0]   act_split;
    logic [ADDR_W:0]   act_top;
    logic              x_err;
    logic              x_sel_b;
    logic [ADDR_W-1:0] x_loc;
    logic              busy;

    assign busy = req_valid || out_valid;

    dcam_cfg #(.AW(ADDR_W), .GLG(GRAN_LG)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_mode  (cfg_mode),
        .cfg_split (cfg_split),
        .cfg_top   (cfg_top),
        .busy      (busy),
        .act_mode  (act_mode),
        .act_split (act_split),
        .act_top   (act_top),
        .chb_idle  (chb_idle)
    );

    dcam_xlate #(.AW(ADDR_W), .GLG(GRAN_LG)) u_xlate (
        .mode  (act_mode),
        .split (act_split),
        .top   (act_top),
        .addr  (req_addr),
        .err   (x_err),
        .sel_b (x_sel_b),
        .loc   (x_loc)
    );

    dcam_ostage #(.AW(ADDR_W)) u_ostage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_err    (x_err),
        .in_sel_b  (x_sel_b),
        .in_loc    (x_loc),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_err   (out_err),
        .out_sel_b (out_sel_b),
        .out_loc   (out_loc)
    );

endmodule

// File: rtl/dcam_chk.sv
module dcam_chk
    import dcam_pkg::*;
#(
    parameter int AW  = 16,
    parameter int GLG = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_wr,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          out_valid,
    input logic          out_ready,
    input logic          out_err,
    input logic          out_sel_b,
    input logic [AW-1:0] out_loc,
    input logic          chb_idle,
    input map_mode_e     act_mode
);
    // R9
    acc_lat_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> out_valid);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_loc)
                                    && $stable(out_sel_b) && $stable(out_err));

    // R10
    bp_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !req_ready);

    // R6
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_err |-> !out_sel_b && (out_loc == '0));

    // R2
    stripe_sel_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && (act_mode == MAP_STRIPE)
        |=> out_err || (out_sel_b == $past(req_addr[GLG])));

    // R8
    cfg_gate_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr && (req_valid || out_valid) |=> $stable(act_mode));

    // R7
    idle_stripe_chk: assert property (@(posedge clk) disable iff (rst)
        (act_mode == MAP_STRIPE) |-> !chb_idle);

endmodule

bind dcam_top dcam_chk #(.AW(ADDR_W), .GLG(GRAN_LG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_err   (out_err),
    .out_sel_b (out_sel_b),
    .out_loc   (out_loc),
    .chb_idle  (chb_idle),
    .act_mode  (act_mode)
);

// File: tb/dcam_top_tb.sv
module dcam_top_tb;
    localparam int AW = 10;
    localparam int SPAN = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_mode = '0;
    logic [AW:0]   cfg_split = '0;
    logic [AW:0]   cfg_top = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic          out_err;
    logic          out_sel_b;
    logic [AW-1:0] out_loc;
    logic          chb_idle;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    dcam_top #(.ADDR_W(AW), .GRAN_LG(5)) u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_split(cfg_split), .cfg_top(cfg_top), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .out_valid(out_valid),
        .out_ready(out_ready), .out_err(out_err), .out_sel_b(out_sel_b),
        .out_loc(out_loc), .chb_idle(chb_idle)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL R9 watchdog expired actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int outcode();
        return (int'(out_valid) << 12) | (int'(out_err) << 11)
             | (int'(out_sel_b) << 10) | int'(out_loc);
    endfunction

    function automatic int pack(input int err, input int sel, input int loc);
        return (1 << 12) | (err << 11) | (sel << 10) | loc;
    endfunction

    // Reference map computed arithmetically from the requirements.
    function automatic int model(input int mode, input int split, input int top, input int a);
        int sa, d, q, sel;
        if (a >= top) return pack(1, 0, 0);
        if (mode == 1) begin
            sel = (a / 32) % 2;
            return pack(0, sel, (a / 64) * 32 + a % 32);
        end
        if (mode == 2) begin
            sa = (split / 64) * 64;
            if (a < sa) return pack(0, 0, a);
            d = a - sa;
            sel = (d / 32) % 2;
            q = (d / 64) * 32 + d % 32;
            return pack(0, sel, sel ? q : sa + q);
        end
        if (a >= split) return pack(0, 1, a - split);
        return pack(0, 0, a);
    endfunction

    function automatic int idle_model(input int mode, input int split, input int top);
        if (mode == 1) return 0;
        if (mode == 2) return ((split / 64) * 64 >= top) ? 1 : 0;
        return (split >= top) ? 1 : 0;
    endfunction

    task automatic configure(input int mode, input int split, input int top);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_mode = 2'(mode);
        cfg_split = (AW+1)'(split);
        cfg_top = (AW+1)'(top);
        @(negedge clk);
        cfg_wr = 1'b0;
        check("R7 chb_idle after config", int'(chb_idle), idle_model(mode, split, top));
    endtask

    task automatic sweep(input string tag, input int mode, input int split, input int top);
        int exp_prev = 0;
        bit have = 0;
        configure(mode, split, top);
        for (int a = 0; a < SPAN; a++) begin
            @(negedge clk);
            if (have) check(tag, outcode(), exp_prev);
            req_valid = 1'b1;
            req_addr = AW'(a);
            exp_prev = model(mode, split, top, a);
            have = 1;
        end
        @(negedge clk);
        check(tag, outcode(), exp_prev);
        req_valid = 1'b0;
        @(negedge clk);
        check("R9 drained", int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 out_valid after reset", int'(out_valid), 0);
        check("R12 req_ready after reset", int'(req_ready), 1);
        check("R12 chb_idle after reset", int'(chb_idle), 1);

        sweep("R1 separate map", 0, 384, 1000);
        sweep("R11 reserved code as separate", 3, 500, 1024);
        sweep("R2 striped map", 1, 0, 1024);
        sweep("R6 striped map with capacity limit", 1, 0, 768);
        sweep("R3 R4 mixed map", 2, 256, 900);
        sweep("R5 mixed map unaligned boundary", 2, 300, 1024);

        configure(0, 1024, 1000);
        configure(2, 960, 960);
        configure(2, 1000, 960);
        configure(2, 900, 1024);
        configure(3, 200, 1024);

        // Back-pressure and refused configuration write.
        configure(0, 1024, 1024);
        @(negedge clk);
        out_ready = 1'b0;
        req_valid = 1'b1;
        req_addr = AW'(40);
        @(negedge clk);
        check("R10 first result", outcode(), pack(0, 0, 40));
        check("R10 req_ready low while held", int'(req_ready), 0);
        req_addr = AW'(41);
        cfg_wr = 1'b1;
        cfg_mode = 2'd1;
        cfg_split = '0;
        cfg_top = (AW+1)'(512);
        @(negedge clk);
        cfg_wr = 1'b0;
        check("R10 result held", outcode(), pack(0, 0, 40));
        check("R10 req_ready still low", int'(req_ready), 0);
        check("R8 chb_idle unchanged by refused write", int'(chb_idle), 1);
        @(negedge clk);
        check("R10 result held again", outcode(), pack(0, 0, 40));
        out_ready = 1'b1;
        @(negedge clk);
        check("R10 held-off request emerges", outcode(), pack(0, 0, 41));
        req_addr = AW'(600);
        @(negedge clk);
        check("R8 old map still in force", outcode(), pack(0, 0, 600));
        req_valid = 1'b0;
        @(negedge clk);
        check("R9 idle after stream", int'(out_valid), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule